// File: doc/BRIEF.md
# Pseudowire ATM Cell Demultiplexer

This block sits at the egress edge of a packet network that carries ATM traffic over pseudowires. It takes a pseudowire packet payload as a byte stream after the label stack has been removed, along with a small pseudowire identifier. It splits the payload into the ATM cells it carries and emits each one as a complete 53-byte cell on a byte-stream output toward the customer-facing port.

Each pseudowire uses one of three encapsulations. They differ in how many header fields travel inside the packet. A per-pseudowire configuration table holds the encapsulation, the fixed VPI and VCI values used to fill in any field that is not carried, and the largest number of cells a packet may hold. A single control byte comes before every cell. Its payload type and loss priority bits go into the rebuilt header, and the header check byte is computed again.

A whole packet is stored and validated before any cell is sent. A malformed packet is therefore discarded without emitting a partial cell. Input is held off while stored cells are being sent.

Top module: `pw_cell_demux`

## Requirements
- R1: The encapsulation code sets the per-cell stride inside the packet. Code 0 (single channel) uses 49 bytes: control, then 48 payload. Code 1 (single path) uses 51 bytes: control, VCI high byte, VCI low byte, then 48 payload. Code 2 (multi-connection) uses 52 bytes: control, VPI, VCI high, VCI low, then 48 payload. A valid packet of N cells produces exactly N output cells.
- R2: The rebuilt header byte 0 is {4'h0, VPI[7:4]}, byte 1 is {VPI[3:0], VCI[15:12]}, byte 2 is VCI[11:4], and bits 7:4 of byte 3 are VCI[3:0]. VPI comes from the packet only for code 2, and otherwise from the table. VCI comes from the packet for codes 1 and 2, and from the table for code 0.
- R3: Byte 3 bits 3:1 (payload type) are bits 3:1 of that cell's own control byte. Byte 3 bit 0 (loss priority) is bit 0 of that control byte. The other control bits are ignored.
- R4: Header byte 4 is the CRC-8 (polynomial x^8+x^2+x+1, initial value zero, MSB first) of header bytes 0 to 3, XORed with 0x55.
- R5: Each output cell is 53 bytes. out_sop marks byte 0 and out_eop marks byte 52. Bytes 5 to 52 are the cell's 48 payload bytes in order. Cells leave in packet order.
- R6: A packet whose length is not a whole multiple of its stride produces no output cell. One single-cycle drop_err pulse is raised for it in the cycle after its last byte is accepted.
- R7: A packet holding more cells than the table's maximum for its pseudowire (capped at MAX_CELLS) is dropped in the same way as R6.
- R8: A packet on a pseudowire configured with encapsulation code 3 is dropped in the same way as R6.
- R9: in_ready is low from the cycle after the last byte of a valid packet is accepted until the last byte of its last cell has been transferred.
- R10: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold steady.
- R11: After reset, out_valid and drop_err are low and in_ready is high. Every table entry reads as code 0 with a maximum of 0, so any packet is dropped until the entry is written with cfg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | $clog2(NUM_PW) | Entry to write |
| cfg_fmt | input | 2 | Encapsulation code |
| cfg_vpi | input | 8 | Fixed VPI |
| cfg_vci | input | 16 | Fixed VCI |
| cfg_maxc | input | $clog2(MAX_CELLS+1) | Largest cell count per packet |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_pw | input | $clog2(NUM_PW) | Pseudowire id, sampled with in_sop |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte taken |
| out_sop | output | 1 | First byte of a cell |
| out_eop | output | 1 | Last byte of a cell |
| out_data | output | 8 | Output byte |
| drop_err | output | 1 | Packet dropped pulse |

## Verification
The bench sends packets whose lengths sit one byte short of and one byte past a whole number of cells. A design that checks only the cell count would let these through, and a truncated last cell would leak out. Packets of exactly the configured maximum and one cell more are sent on every encapsulation, which catches an off-by-one limit that drops good packets or passes oversized ones. Each cell carries different control, VPI and VCI bytes, so taking a header field from the wrong source, from a stale cell, or at the wrong offset shows up as a header or check-byte mismatch. Random output backpressure exercises the hold rule, and the input-stall rule is checked at every cell start.

// File: rtl/pw_cell_demux.sv
module pw_cell_demux #(
  parameter int NUM_PW    = 4,
  parameter int MAX_CELLS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [$clog2(NUM_PW)-1:0]      cfg_idx,
  input  logic [1:0]                     cfg_fmt,
  input  logic [7:0]                     cfg_vpi,
  input  logic [15:0]                    cfg_vci,
  input  logic [$clog2(MAX_CELLS+1)-1:0] cfg_maxc,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_sop,
  input  logic                           in_eop,
  input  logic [$clog2(NUM_PW)-1:0]      in_pw,
  input  logic [7:0]                     in_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_sop,
  output logic                           out_eop,
  output logic [7:0]                     out_data,
  output logic                           drop_err
);
  localparam int PW_W  = $clog2(NUM_PW);
  localparam int MC_W  = $clog2(MAX_CELLS+1);
  localparam int CW    = MC_W + 1;
  localparam int DEPTH = MAX_CELLS * 52;
  localparam int AW    = $clog2(DEPTH);

  logic [1:0]      fmt_q  [NUM_PW];
  logic [7:0]      vpi_q  [NUM_PW];
  logic [15:0]     vci_q  [NUM_PW];
  logic [MC_W-1:0] maxc_q [NUM_PW];
  logic [7:0]      mem    [DEPTH];

  logic            tx;
  logic [PW_W-1:0] cur_pw;
  logic [5:0]      pos;
  logic [CW-1:0]   cidx;
  logic [AW-1:0]   wptr;
  logic [MC_W-1:0] ncells, tcell;
  logic [AW-1:0]   base;
  logic [5:0]      j;

  function automatic logic [7:0] hec8(input logic [31:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  logic [PW_W-1:0] sel_pw;
  logic [1:0]      fmt;
  logic [5:0]      stride, hlen;
  logic [CW-1:0]   lim;
  assign sel_pw = (!tx && in_sop) ? in_pw : cur_pw;
  assign fmt    = fmt_q[sel_pw];
  assign stride = (fmt == 2'd0) ? 6'd49 : (fmt == 2'd1) ? 6'd51 : 6'd52;
  assign hlen   = stride - 6'd48;
  assign lim    = ({1'b0, maxc_q[sel_pw]} > CW'(MAX_CELLS)) ? CW'(MAX_CELLS) : {1'b0, maxc_q[sel_pw]};

  logic          acc, last, fits, pkt_ok;
  logic [5:0]    p;
  logic [CW-1:0] c;
  logic [AW-1:0] w;
  assign in_ready = !tx;
  assign acc      = in_valid && !tx;
  assign p        = in_sop ? 6'd0 : pos;
  assign c        = in_sop ? '0 : cidx;
  assign w        = in_sop ? '0 : wptr;
  assign last     = (p == stride - 6'd1);
  assign fits     = (c < lim);
  assign pkt_ok   = last && fits && (fmt != 2'd3);

  logic [7:0]    ctl, b1, b2, b3, vpi;
  logic [15:0]   vci;
  logic [31:0]   hdr;
  logic [AW-1:0] pidx;
  assign ctl  = mem[base];
  assign b1   = mem[base + AW'(1)];
  assign b2   = mem[base + AW'(2)];
  assign b3   = mem[base + AW'(3)];
  assign vpi  = (fmt == 2'd2) ? b1 : vpi_q[cur_pw];
  assign vci  = (fmt == 2'd1) ? {b1, b2} : (fmt == 2'd2) ? {b2, b3} : vci_q[cur_pw];
  assign hdr  = {4'h0, vpi, vci, ctl[3:1], ctl[0]};
  assign pidx = base + AW'(hlen) + AW'(j) - AW'(5);

  always_comb begin
    case (j)
      6'd0:    out_data = hdr[31:24];
      6'd1:    out_data = hdr[23:16];
      6'd2:    out_data = hdr[15:8];
      6'd3:    out_data = hdr[7:0];
      6'd4:    out_data = hec8(hdr);
      default: out_data = mem[pidx];
    endcase
  end
  assign out_valid = tx;
  assign out_sop   = tx && (j == 6'd0);
  assign out_eop   = tx && (j == 6'd52);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PW; k++) begin
        fmt_q[k]  <= 2'd0;
        vpi_q[k]  <= 8'h00;
        vci_q[k]  <= 16'h0000;
        maxc_q[k] <= '0;
      end
    end else if (cfg_we) begin
      fmt_q[cfg_idx]  <= cfg_fmt;
      vpi_q[cfg_idx]  <= cfg_vpi;
      vci_q[cfg_idx]  <= cfg_vci;
      maxc_q[cfg_idx] <= cfg_maxc;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && fits) mem[w] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx       <= 1'b0;
      cur_pw   <= '0;
      pos      <= '0;
      cidx     <= '0;
      wptr     <= '0;
      ncells   <= '0;
      tcell    <= '0;
      base     <= '0;
      j        <= '0;
      drop_err <= 1'b0;
    end else begin
      drop_err <= acc && in_eop && !pkt_ok;
      if (acc) begin
        if (in_sop) cur_pw <= in_pw;
        pos  <= last ? 6'd0 : p + 6'd1;
        cidx <= last ? c + CW'(c != {CW{1'b1}}) : c;
        wptr <= w + AW'(fits);
        if (in_eop && pkt_ok) begin
          tx     <= 1'b1;
          ncells <= c[MC_W-1:0] + MC_W'(1);
          tcell  <= '0;
          base   <= '0;
          j      <= '0;
        end
      end else if (tx && out_ready) begin
        if (j == 6'd52) begin
          j    <= '0;
          base <= base + AW'(stride);
          if (tcell + MC_W'(1) == ncells) tx <= 1'b0;
          else tcell <= tcell + MC_W'(1);
        end else begin
          j <= j + 6'd1;
        end
      end
    end
  end

  AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready); // R9
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R10
  AST_CELL_FRAME: assert property (@(posedge clk) disable iff (!rst_n) out_sop |-> !out_eop); // R5
  AST_START_SOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> out_sop); // R5
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) drop_err |-> !out_valid); // R6
endmodule

// File: tb/pw_cell_demux_bench.sv
module pw_cell_demux_bench;
  localparam int CLK_NS = 10;

  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0;
  logic [1:0] cfg_idx = 0, cfg_fmt = 0, in_pw = 0;
  logic [7:0] cfg_vpi = 0, in_data = 0;
  logic [15:0] cfg_vci = 0;
  logic [3:0] cfg_maxc = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0;
  logic in_ready, out_valid, out_sop, out_eop, drop_err;
  logic [7:0] out_data;

  always #(CLK_NS/2) clk = ~clk;

  pw_cell_demux u_pw_cell_demux (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_fmt, .cfg_vpi, .cfg_vci, .cfg_maxc,
    .in_valid, .in_ready, .in_sop, .in_eop, .in_pw, .in_data,
    .out_valid, .out_ready, .out_sop, .out_eop, .out_data, .drop_err);

  int n_chk = 0, n_bad = 0;
  logic [1:0]  s_fmt [4];
  logic [7:0]  s_vpi [4];
  logic [15:0] s_vci [4];
  int          s_max [4];
  logic [7:0]  pk [0:511];
  logic [7:0]  exp_buf [0:8*53-1];
  int exp_cells = 0, got_cells = 0, err_cnt = 0, mc = 0;
  logic [7:0] cur [0:52];
  logic sop_ok = 1, eop_ok = 1;
  int bp_pct = 100;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] d);
    logic [39:0] v;
    v = {d, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v = v ^ (40'h107 << (i - 8));
    return v[7:0] ^ 8'h55;
  endfunction

  function automatic int stride_of(input logic [1:0] f);
    return (f == 2'd0) ? 49 : (f == 2'd1) ? 51 : 52;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (drop_err) err_cnt++;
      if (out_valid && out_ready) begin
        if (out_sop) chk(!in_ready, "R9 input stalled during cell output", in_ready, 0);
        if (mc <= 52) cur[mc] = out_data;
        if ((mc == 0) != out_sop) sop_ok = 0;
        if ((mc == 52) != out_eop) eop_ok = 0;
        mc++;
        if (out_eop || mc > 52) begin
          if (got_cells >= exp_cells) chk(0, "R6 unexpected output cell", got_cells, exp_cells);
          else begin
            int b; bit pl_ok; int bad_i;
            b = got_cells * 53;
            chk(cur[0] == exp_buf[b] && cur[1] == exp_buf[b+1] && cur[2] == exp_buf[b+2] &&
                cur[3][7:4] == exp_buf[b+3][7:4], "R2 header VPI/VCI",
                {cur[0], cur[1], cur[2], cur[3]}, {exp_buf[b], exp_buf[b+1], exp_buf[b+2], exp_buf[b+3]});
            chk(cur[3][3:0] == exp_buf[b+3][3:0], "R3 PTI/CLP", cur[3][3:0], exp_buf[b+3][3:0]);
            chk(cur[4] == exp_buf[b+4], "R4 HEC", cur[4], exp_buf[b+4]);
            pl_ok = sop_ok && eop_ok && mc == 53; bad_i = 0;
            for (int i = 5; i < 53; i++)
              if (cur[i] !== exp_buf[b+i] && pl_ok) begin pl_ok = 0; bad_i = i; end
            chk(pl_ok, "R5 framing/payload", cur[bad_i], exp_buf[b+bad_i]);
          end
          got_cells++;
          mc = 0; sop_ok = 1; eop_ok = 1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom % 100) < bp_pct;
    end
  end

  task automatic cfg(input int idx, input logic [1:0] f, input logic [7:0] vp,
                     input logic [15:0] vc, input int mx);
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = idx[1:0]; cfg_fmt = f; cfg_vpi = vp; cfg_vci = vc; cfg_maxc = mx[3:0];
    s_fmt[idx] = f; s_vpi[idx] = vp; s_vci[idx] = vc; s_max[idx] = mx;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(input int pw, input int ncell, input int adj, input string tag);
    int st, len, e0, i;
    bit ok;
    logic [7:0] ct, vp, vh, vl;
    logic [7:0] hv;
    logic [15:0] hc;
    logic [31:0] h;
    st  = stride_of(s_fmt[pw]);
    len = ncell * st + adj;
    ok  = (adj == 0) && (ncell <= s_max[pw]) && (s_fmt[pw] != 2'd3);
    for (int k = 0; k < ncell + 1; k++) begin
      ct = 8'($urandom); vp = 8'($urandom); vh = 8'($urandom); vl = 8'($urandom);
      for (int q = 0; q < st; q++) begin
        int o; o = k * st + q;
        if (o < 512) begin
          if (q == 0) pk[o] = ct;
          else if (s_fmt[pw] == 2'd1 && q == 1) pk[o] = vh;
          else if (s_fmt[pw] == 2'd1 && q == 2) pk[o] = vl;
          else if (s_fmt[pw] == 2'd2 && q == 1) pk[o] = vp;
          else if (s_fmt[pw] == 2'd2 && q == 2) pk[o] = vh;
          else if (s_fmt[pw] == 2'd2 && q == 3) pk[o] = vl;
          else pk[o] = 8'($urandom);
        end
      end
      if (ok && k < ncell) begin
        hv = (s_fmt[pw] == 2'd2) ? vp : s_vpi[pw];
        hc = (s_fmt[pw] == 2'd0) ? s_vci[pw] : {vh, vl};
        h  = {4'h0, hv, hc, ct[3:0]};
        exp_buf[k*53]   = h[31:24];
        exp_buf[k*53+1] = h[23:16];
        exp_buf[k*53+2] = h[15:8];
        exp_buf[k*53+3] = h[7:0];
        exp_buf[k*53+4] = ref_hec(h);
        for (int q = 0; q < 48; q++) exp_buf[k*53+5+q] = pk[k*st + (st - 48) + q];
      end
    end
    exp_cells = ok ? ncell : 0;
    got_cells = 0;
    e0 = err_cnt;
    i = 0;
    while (i < len) begin
      @(posedge clk); #1;
      if ($urandom % 10 == 0) in_valid = 0;
      else begin
        in_valid = 1; in_data = pk[i]; in_sop = (i == 0); in_eop = (i == len - 1);
        in_pw = pw[1:0];
        @(negedge clk);
        if (in_ready) i++;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; in_sop = 0; in_eop = 0;
    repeat (2) @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(got_cells == exp_cells, {"R1 cell count ", tag}, got_cells, exp_cells);
    chk(err_cnt - e0 == (ok ? 0 : 1), {"drop pulse ", tag}, err_cnt - e0, ok ? 0 : 1);
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int k = 0; k < 4; k++) begin s_fmt[k] = 0; s_vpi[k] = 0; s_vci[k] = 0; s_max[k] = 0; end
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !out_valid && !drop_err, "R11 reset outputs",
        {in_ready, out_valid, drop_err}, 3'b100);
    send(1, 1, 0, "R11 unwritten entry drops");

    cfg(0, 2'd0, 8'hA5, 16'h1234, 3);
    cfg(1, 2'd1, 8'h3C, 16'hBEEF, 8);
    cfg(2, 2'd2, 8'h00, 16'h0000, 5);
    cfg(3, 2'd3, 8'h11, 16'h2222, 4);
    bp_pct = 100;
    send(0, 1, 0, "R1 VCC single");
    send(1, 2, 0, "R1 VPC pair");
    send(2, 3, 0, "R1 N1 triple");
    bp_pct = 60;
    send(0, 3, 0, "R7 VCC at max");
    send(0, 4, 0, "R7 VCC over max");
    send(1, 8, 0, "R7 VPC at cap");
    send(1, 9, 0, "R7 VPC over cap");
    send(2, 5, 0, "R7 N1 at max");
    send(2, 6, 0, "R7 N1 over max");
    send(0, 2, -1, "R6 short");
    send(1, 2, 1, "R6 long");
    send(2, 1, -1, "R6 short one cell");
    send(2, 1, 30, "R6 partial second");
    send(3, 1, 0, "R8 reserved format");
    cfg(3, 2'd2, 8'h77, 16'h0F0F, 8);
    send(3, 8, 0, "R1 N1 full cap");

    for (int r = 0; r < 110; r++) begin
      int pw, nc, adj, sel;
      if (r % 25 == 0)
        cfg(r / 25 % 4, 2'($urandom % 4), 8'($urandom), 16'($urandom), 1 + $urandom % 8);
      bp_pct = 40 + $urandom % 61;
      pw  = $urandom % 4;
      sel = $urandom % 10;
      nc  = 1 + $urandom % 8;
      adj = (sel == 0) ? -1 : (sel == 1) ? 1 : 0;
      send(pw, nc, adj, "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule